// File: doc/BRIEF.md
# HDLC Channel Event Statistics Counters

This block keeps five 16-bit statistics counters for one HDLC channel. The receive frame logic raises a one-cycle frame-end strobe together with qualifier levels: CRC good, overrun, address recognised, and no free buffer. A separate strobe marks a frame dropped while the receiver was busy. The abort detector and the transmit collision logic each supply their own one-cycle strobe. A small qualifier stage decides which counter, if any, each event feeds. Each counter then adds the number of events aimed at it in that cycle. The counters wrap modulo 65536.

Host software reads any counter through a 3-bit select, and the read data is combinational. Software may preload a counter only while the channel enable is low. Writes made while the channel runs are dropped, and the counters keep running. Counter selects are encoded as 0 = discarded frames, 1 = CRC errors, 2 = aborts, 3 = unmatched addresses, 4 = retransmissions. Selects 5 to 7 are unused.

Top module: `hdlc_rx_stat_bank`

## Requirements
- R1: After the active-low asynchronous reset, all five counters read zero.
- R2: Every counter is 16 bits and wraps from 0xFFFF to 0x0000 with no saturation. A +2 step from 0xFFFF gives 0x0001.
- R3: The discard counter (select 0) adds one for a frame end with CRC good, no overrun, address recognised and no free buffer. It does not count in any other case.
- R4: The CRC counter (select 1) adds one for a frame end with bad CRC and no overrun, whether or not the address was recognised. It adds one for each busy-drop strobe. When both occur in the same cycle, it adds two.
- R5: A frame end with overrun set changes none of the discard, CRC or unmatched-address counters. A busy-drop strobe in the same cycle still counts.
- R6: The unmatched-address counter (select 3) adds one for a frame end with CRC good, no overrun and address not recognised. The no-buffer qualifier has no effect on it.
- R7: The abort counter (select 2) adds one per abort strobe.
- R8: The retransmission counter (select 4) adds one per collision retransmission strobe.
- R9: A host write with the channel enable low loads the selected counter, and the value is readable the next cycle. The write takes priority over an event aimed at the same counter in that cycle.
- R10: The read data equals the selected counter combinationally. Selects 5 to 7 read zero, and writes to them change no counter.
- R11: A host write while the channel enable is high is ignored. Events in the same cycle still count.
- R12: A frame end is counted only on its strobe. Qualifier levels without the strobe change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chan_en_i | input | 1 | Channel enable; high blocks host writes |
| frame_end_i | input | 1 | One-cycle strobe at the end of a received frame |
| crc_ok_i | input | 1 | Qualifier: frame CRC good |
| overrun_i | input | 1 | Qualifier: frame ended in an overrun |
| addr_hit_i | input | 1 | Qualifier: frame address recognised |
| no_buf_i | input | 1 | Qualifier: no free buffer for the frame |
| busy_drop_i | input | 1 | Strobe: frame dropped in the busy condition |
| abort_i | input | 1 | Strobe: abort sequence received |
| retx_i | input | 1 | Strobe: frame resent after a collision |
| host_we_i | input | 1 | Host write strobe |
| host_sel_i | input | 3 | Counter select for read and write |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Selected counter value |

## Verification
The assertions check on every cycle that:
- an overrun frame end feeds no frame-derived counter;
- one frame end feeds at most one counter;
- a counter holds its value when it has no event;
- a counter steps by exactly its event count;
- a write while disabled loads the written value;
- unused selects read zero.

Only the bench scenarios can show that each qualifier combination reaches the right counter. The same holds for the wrap values at 0xFFFF, for write priority over a coincident event, and for writes dropped while enabled. Each of these needs a specific stimulus sequence followed by read-back through the host port.

// File: rtl/hdlc_stat_pkg.sv
package hdlc_stat_pkg;
  localparam int NUM_CNT = 5;
  localparam int SEL_W   = 3;
  localparam int INC_W   = 2;

  typedef enum logic [SEL_W-1:0] {
    CNT_DISC = 3'd0,
    CNT_CRC  = 3'd1,
    CNT_ABRT = 3'd2,
    CNT_NMA  = 3'd3,
    CNT_RETX = 3'd4
  } cnt_id_e;
endpackage

// File: rtl/hdlc_stat_qual.sv
module hdlc_stat_qual
  import hdlc_stat_pkg::*;
(
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             frame_end_i,
  input  logic                             crc_ok_i,
  input  logic                             overrun_i,
  input  logic                             addr_hit_i,
  input  logic                             no_buf_i,
  input  logic                             busy_drop_i,
  input  logic                             abort_i,
  input  logic                             retx_i,
  output logic [NUM_CNT-1:0][INC_W-1:0]    inc_o
);
  logic frame_ok, ev_disc, ev_nma, ev_crc;

  always_comb begin
    frame_ok = frame_end_i && !overrun_i;
    ev_disc  = frame_ok && crc_ok_i && addr_hit_i && no_buf_i;
    ev_nma   = frame_ok && crc_ok_i && !addr_hit_i;
    ev_crc   = frame_ok && !crc_ok_i;
  end

  always_comb begin
    inc_o                = '0;
    inc_o[int'(CNT_DISC)] = INC_W'(ev_disc);
    inc_o[int'(CNT_NMA)]  = INC_W'(ev_nma);
    inc_o[int'(CNT_CRC)]  = INC_W'(ev_crc) + INC_W'(busy_drop_i);
    inc_o[int'(CNT_ABRT)] = INC_W'(abort_i);
    inc_o[int'(CNT_RETX)] = INC_W'(retx_i);
  end

  // R5
  ovr_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && overrun_i) |->
      (inc_o[int'(CNT_DISC)] == '0 && inc_o[int'(CNT_NMA)] == '0 &&
       inc_o[int'(CNT_CRC)] == INC_W'(busy_drop_i)));

  // R3 R6: one frame end feeds at most one frame counter
  one_frame_one_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ev_disc, ev_nma, ev_crc}));

  // R12
  no_strobe_no_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |-> (inc_o[int'(CNT_DISC)] == '0 && inc_o[int'(CNT_NMA)] == '0));
endmodule

// File: rtl/hdlc_stat_ctr.sv
module hdlc_stat_ctr #(
  parameter int W     = 16,
  parameter int INC_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [W-1:0]     cnt_o
);
  logic [W-1:0] cnt_q;
  logic         load;

  assign load  = wr_i && !en_i;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (load)  cnt_q <= wdata_i;
    else            cnt_q <= cnt_q + W'(inc_i);
  end

  // R11
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && inc_i == '0) |=> cnt_q == $past(cnt_q));

  // R9
  wr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && wr_i) |=> cnt_q == $past(wdata_i));

  // R2
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && inc_i != '0) |=> (cnt_q - $past(cnt_q)) == W'($past(inc_i)));
endmodule

// File: rtl/hdlc_stat_rdmux.sv
module hdlc_stat_rdmux #(
  parameter int W     = 16,
  parameter int N     = 5,
  parameter int SEL_W = 3
) (
  input  logic [N-1:0][W-1:0] cnt_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic [W-1:0]        rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N; k++)
      if (sel_i == SEL_W'(k)) rdata_o = cnt_i[k];
  end
endmodule

// File: rtl/hdlc_rx_stat_bank.sv
module hdlc_rx_stat_bank
  import hdlc_stat_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chan_en_i,
  input  logic             frame_end_i,
  input  logic             crc_ok_i,
  input  logic             overrun_i,
  input  logic             addr_hit_i,
  input  logic             no_buf_i,
  input  logic             busy_drop_i,
  input  logic             abort_i,
  input  logic             retx_i,
  input  logic             host_we_i,
  input  logic [SEL_W-1:0] host_sel_i,
  input  logic [CNT_W-1:0] host_wdata_i,
  output logic [CNT_W-1:0] host_rdata_o
);
  logic [NUM_CNT-1:0][INC_W-1:0] inc;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
  logic [NUM_CNT-1:0]            wr;

  hdlc_stat_qual u_qual (
    .clk_i, .rst_ni, .frame_end_i, .crc_ok_i, .overrun_i, .addr_hit_i,
    .no_buf_i, .busy_drop_i, .abort_i, .retx_i, .inc_o(inc)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_ctr
    assign wr[k] = host_we_i && (host_sel_i == SEL_W'(k));
    hdlc_stat_ctr #(.W(CNT_W), .INC_W(INC_W)) u_ctr (
      .clk_i, .rst_ni, .en_i(chan_en_i), .wr_i(wr[k]),
      .wdata_i(host_wdata_i), .inc_i(inc[k]), .cnt_o(cnt[k])
    );
  end

  hdlc_stat_rdmux #(.W(CNT_W), .N(NUM_CNT), .SEL_W(SEL_W)) u_rdmux (
    .cnt_i(cnt), .sel_i(host_sel_i), .rdata_o(host_rdata_o)
  );

  // R10
  hole_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_sel_i >= SEL_W'(NUM_CNT)) |-> host_rdata_o == '0);

  // R10
  hole_write_inert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_sel_i >= SEL_W'(NUM_CNT)) |-> wr == '0);
endmodule

// File: tb/sim_hdlc_rx_stat_bank.sv
module sim_hdlc_rx_stat_bank;
  logic clk = 0, rst_n = 0, en = 0;
  logic fe = 0, crc_ok = 0, ovr = 0, ahit = 0, nobuf = 0, bdrop = 0, abrt = 0, retx = 0;
  logic we = 0;
  logic [2:0] sel = 0;
  logic [15:0] wdata = 0, rdata;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] exp_c [5];

  always #5 clk = ~clk;

  hdlc_rx_stat_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .chan_en_i(en), .frame_end_i(fe), .crc_ok_i(crc_ok),
    .overrun_i(ovr), .addr_hit_i(ahit), .no_buf_i(nobuf), .busy_drop_i(bdrop),
    .abort_i(abrt), .retx_i(retx), .host_we_i(we), .host_sel_i(sel),
    .host_wdata_i(wdata), .host_rdata_o(rdata)
  );

  // stim {fe,crc_ok,ovr,ahit,nobuf,bdrop,abrt,retx}; deltas {retx,nma,abrt,crc,disc}
  localparam int NV = 15;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0,2'd0,2'd0,2'd0,2'd0, 8'b1101_0000},  // good, stored
    {2'd0,2'd0,2'd0,2'd0,2'd1, 8'b1101_1000},  // R3 no buffer
    {2'd0,2'd0,2'd0,2'd1,2'd0, 8'b1001_0000},  // R4 bad crc addressed
    {2'd0,2'd0,2'd0,2'd1,2'd0, 8'b1000_0000},  // R4 bad crc unaddressed
    {2'd0,2'd1,2'd0,2'd0,2'd0, 8'b1100_0000},  // R6
    {2'd0,2'd1,2'd0,2'd0,2'd0, 8'b1100_1000},  // R6 no buffer ignored
    {2'd0,2'd0,2'd0,2'd0,2'd0, 8'b1011_1000},  // R5 overrun bad crc
    {2'd0,2'd0,2'd0,2'd0,2'd0, 8'b1110_0000},  // R5 overrun unaddressed
    {2'd0,2'd0,2'd0,2'd1,2'd0, 8'b1010_0100},  // R5 overrun + busy drop
    {2'd0,2'd0,2'd0,2'd1,2'd0, 8'b0000_0100},  // R4 busy drop
    {2'd0,2'd0,2'd0,2'd2,2'd0, 8'b1000_0100},  // R4 double
    {2'd0,2'd0,2'd1,2'd0,2'd0, 8'b0000_0010},  // R7
    {2'd1,2'd0,2'd0,2'd0,2'd0, 8'b0000_0001},  // R8
    {2'd1,2'd0,2'd1,2'd0,2'd1, 8'b1101_1011},  // R3 R7 R8 together
    {2'd0,2'd0,2'd0,2'd0,2'd0, 8'b0101_1000}   // R12 qualifiers without strobe
  };
  localparam string TAG [5] = '{"R3", "R4", "R7", "R6", "R8"};

  task automatic rd_chk(input logic [2:0] s, input logic [15:0 ] e, input string tag);
    sel = s;
    #1;
    checks++;
    if (rdata !== e) begin
      fails++;
      $display("FAIL %s sel=%0d got=%h exp=%h", tag, s, rdata, e);
    end
  endtask

  task automatic chk_all(input string tag);
    for (int k = 0; k < 5; k++) rd_chk(3'(k), exp_c[k], tag);
  endtask

  task automatic pulse(input logic [7:0] s);
    @(negedge clk);
    {fe, crc_ok, ovr, ahit, nobuf, bdrop, abrt, retx} = s;
    @(negedge clk);
    {fe, crc_ok, ovr, ahit, nobuf, bdrop, abrt, retx} = '0;
  endtask

  task automatic hwrite(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    we = 1; sel = s; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 5; k++) exp_c[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_all("R1");

    en = 1;
    for (int v = 0; v < NV; v++) begin
      pulse(VEC[v][7:0]);
      for (int k = 0; k < 5; k++) begin
        exp_c[k] = exp_c[k] + 16'(VEC[v][8+2*k +: 2]);
        rd_chk(3'(k), exp_c[k], TAG[k]);
      end
    end

    // R11 write while enabled ignored
    hwrite(3'd0, 16'h1234);
    rd_chk(3'd0, exp_c[0], "R11");
    @(negedge clk);
    we = 1; sel = 3'd2; wdata = 16'h0BAD; abrt = 1;
    @(negedge clk);
    we = 0; abrt = 0;
    exp_c[2] = exp_c[2] + 16'd1;
    rd_chk(3'd2, exp_c[2], "R11");

    // R9 preload while disabled
    en = 0;
    hwrite(3'd2, 16'hFFFF);
    exp_c[2] = 16'hFFFF;
    rd_chk(3'd2, 16'hFFFF, "R9");
    hwrite(3'd1, 16'hFFFF);
    exp_c[1] = 16'hFFFF;
    rd_chk(3'd1, 16'hFFFF, "R9");

    // R2 wrap
    en = 1;
    pulse(8'b0000_0010);
    exp_c[2] = 16'h0000;
    rd_chk(3'd2, 16'h0000, "R2");
    pulse(8'b1000_0100);
    exp_c[1] = 16'h0001;
    rd_chk(3'd1, 16'h0001, "R2");

    // R9 write wins over coincident event
    en = 0;
    @(negedge clk);
    we = 1; sel = 3'd4; wdata = 16'h00A5; retx = 1;
    @(negedge clk);
    we = 0; retx = 0;
    exp_c[4] = 16'h00A5;
    rd_chk(3'd4, 16'h00A5, "R9");

    // R10 unused selects
    rd_chk(3'd5, 16'h0000, "R10");
    rd_chk(3'd7, 16'h0000, "R10");
    hwrite(3'd6, 16'h5A5A);
    rd_chk(3'd6, 16'h0000, "R10");
    chk_all("R10");

    // R5 overrun with every other qualifier pattern
    en = 1;
    pulse(8'b1010_1000);
    pulse(8'b1110_1000);
    chk_all("R5");

    // R1 asynchronous reset mid-run
    #3 rst_n = 0;
    #1;
    for (int k = 0; k < 5; k++) exp_c[k] = '0;
    chk_all("R1");
    rst_n = 1;

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule